// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache with Store Buffer

This block is a 1 KB data cache placed between a processor's load/store port and a memory port. It is organised as two ways of sixteen sets, and each line holds a 32-byte block of eight 32-bit words. For a lookup, the set index selects one entry in each way. Both stored tags are compared against the request tag in the same cycle. The two results are combined into a single hit flag, and they also select which way's word is returned. A read that hits completes in the cycle it is presented.

A read miss stalls the processor and refills the whole block from memory into the least recently used way of the set. The memory returns the eight words in order. The request completes as a hit in the cycle after the last word arrives.

Every store is written through. It updates the cached word when the block is present and is always queued in a four-entry FIFO that the memory side drains one word at a time. A store that misses does not allocate a line. A store stalls only while the FIFO is full. A read miss waits until no queued store targets the same block, so the refill never returns stale data.

The processor holds its request steady while the stall output is high. At most one of the read and write strobes is asserted at a time.

Top module: `wtc_cache`

## Requirements
- R1: The address is split into tag (bits 31:9), set index (bits 8:5) and word select (bits 4:2). A read whose tag matches a valid entry in either way of the indexed set returns that word with cpu_hit high and cpu_stall low in the same cycle.
- R2: A read miss holds cpu_stall high and raises mem_rd_req with mem_rd_addr set to the request address with bits 4:0 cleared. The block keeps mem_rd_req and mem_rd_addr steady until eight mem_rd_valid beats have arrived. The beats carry words 0 to 7 in that order. The request then completes as a hit returning the refilled word.
- R3: Two blocks that map to the same set can be resident at once, one in each way, and both then hit.
- R4: A refill replaces the least recently used way of its set. Any read or write hit makes the hit way most recent, and so does a completed refill. After reset, way 0 of every set is the first victim.
- R5: A store that hits updates the cached word, so a following read of that address hits and returns the stored data.
- R6: A store that misses leaves the cache contents unchanged. A following read of that block misses.
- R7: Every accepted store is queued and presented on mem_wr_req/mem_wr_addr/mem_wr_data. It is held until mem_wr_ack, and stores are drained in acceptance order. A read miss never issues a memory write.
- R8: With four stores queued and none drained, a further store holds cpu_stall high. It is accepted in the cycle after an entry drains.
- R9: A read miss whose block matches any queued store does not raise mem_rd_req until that store has drained.
- R10: After reset all lines are invalid, the FIFO is empty, and mem_rd_req, mem_wr_req and cpu_stall are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Read strobe, held while stalled |
| cpu_wr | input | 1 | Write strobe, held while stalled |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read data, valid when cpu_hit is high on a read |
| cpu_hit | output | 1 | Tag match in either way for the current address |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_rd_req | output | 1 | Block refill request |
| mem_rd_addr | output | 32 | Block-aligned refill address |
| mem_rd_valid | input | 1 | One refill word is present this cycle |
| mem_rd_data | input | 32 | Refill word |
| mem_wr_req | output | 1 | Store buffer head is waiting to drain |
| mem_wr_addr | output | 32 | Address of the head store |
| mem_wr_data | output | 32 | Data of the head store |
| mem_wr_ack | input | 1 | Memory takes the head store this cycle |

## Verification
The replacement order is exercised with a three-block sequence in one set, where each result depends on which way is the victim. A design that tracked recency backwards, or never updated it on hits, would evict the block that was just read and turn the next expected hit into a miss. A store to a block that is not cached is followed at once by a read of that block while memory acknowledgements are withheld. A refill that skipped the buffer check would raise mem_rd_req early and return the old memory word. The buffer is also filled to four entries with the drain blocked, and the fifth store must stall and then drain last. An off-by-one full flag would either accept the fifth store or stall on the fourth.

// File: rtl/wtc_pkg.sv
// Shared constants and types for the two-way write-through cache.
// Assumes a 32-bit byte address and 32-bit words throughout.
package wtc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_WAIT = 2'd1,
        FILL_BUSY = 2'd2
    } fill_state_t;
endpackage

// File: rtl/wtc_way.sv
// One way of the cache: per-set valid bit and tag, plus a word-addressed data block.
// Performs the combinational tag compare for the indexed set.
// Assumes all writes (store hits and refill beats) target the currently indexed set.
module wtc_way
    import wtc_pkg::*;
#(
    parameter int TAG_W   = 23,
    parameter int INDEX_W = 4,
    parameter int WSEL_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   tag,
    input  logic [WSEL_W-1:0]  rd_word,
    output logic               hit,
    output logic [DATA_W-1:0]  rdata,
    input  logic               wr_en,
    input  logic [WSEL_W-1:0]  wr_word,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               inv_en,
    input  logic               fill_done
);
    localparam int SETS  = 1 << INDEX_W;
    localparam int WORDS = 1 << WSEL_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS*WORDS];

    // Tag compare and word select for the indexed set.
    assign hit   = valid_q[idx] && (tag_q[idx] == tag);
    assign rdata = data_q[{idx, rd_word}];

    // Valid bits: cleared by reset or at refill start, set at refill end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inv_en) begin
            valid_q[idx] <= 1'b0;
        end else if (fill_done) begin
            valid_q[idx] <= 1'b1;
        end
    end

    // Tag capture when a refill completes.
    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[idx] <= tag;
        end
    end

    // Word write from a store hit or a refill beat.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[{idx, wr_word}] <= wr_data;
        end
    end
endmodule

// File: rtl/wtc_write_fifo.sv
// Store buffer: a DEPTH-entry FIFO of (address, data) pairs drained toward memory.
// Also reports whether any queued entry falls in a queried block.
// Assumes DEPTH is a power of two and that push is never raised while full.
module wtc_write_fifo
    import wtc_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int BLK_LSB = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [ADDR_W-1:0]         push_addr,
    input  logic [DATA_W-1:0]         push_data,
    input  logic                      pop,
    output logic [ADDR_W-1:0]         head_addr,
    output logic [DATA_W-1:0]         head_data,
    output logic                      not_empty,
    output logic                      full,
    input  logic [ADDR_W-BLK_LSB-1:0] q_blk,
    output logic                      match
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  slot_valid;
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    assign not_empty = slot_valid[rd_ptr];
    assign full      = &slot_valid;
    assign head_addr = slot_addr[rd_ptr];
    assign head_data = slot_data[rd_ptr];

    // Pointer and occupancy update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= '0;
            wr_ptr     <= '0;
            rd_ptr     <= '0;
        end else begin
            if (push) begin
                slot_valid[wr_ptr] <= 1'b1;
                wr_ptr             <= wr_ptr + 1'b1;
            end
            if (pop) begin
                slot_valid[rd_ptr] <= 1'b0;
                rd_ptr             <= rd_ptr + 1'b1;
            end
        end
    end

    // Entry payload capture.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[wr_ptr] <= push_addr;
            slot_data[wr_ptr] <= push_data;
        end
    end

    // Block match across all occupied entries.
    always_comb begin
        match = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_valid[i] && (slot_addr[i][ADDR_W-1:BLK_LSB] == q_blk)) begin
                match = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wtc_cache.sv
// Two-way set-associative write-through data cache with LRU replacement.
// Read hits complete in one cycle. Read misses refill a whole block.
// Stores update a cached word and always pass through the store buffer.
// Assumes the processor holds its request while cpu_stall is high and
// never raises cpu_rd and cpu_wr together.
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int OFFSET_W = 5,
    parameter int INDEX_W  = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int WSEL_W = OFFSET_W - 2;
    localparam int WORDS  = 1 << WSEL_W;
    localparam int SETS   = 1 << INDEX_W;
    localparam int TAG_W  = ADDR_W - OFFSET_W - INDEX_W;
    localparam int BLK_W  = ADDR_W - OFFSET_W;

    // Address fields of the current request.
    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic [WSEL_W-1:0]  req_word;
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_addr[OFFSET_W +: INDEX_W];
    assign req_word = cpu_addr[2 +: WSEL_W];

    fill_state_t        state_q;
    logic [WSEL_W-1:0]  beat_q;
    logic               fill_way_q;
    logic [SETS-1:0]    lru_q;

    logic [NUM_WAYS-1:0] way_hit, way_inv, way_wr, way_fill;
    logic [DATA_W-1:0]   way_rdata [NUM_WAYS];
    logic                hit_any, victim;
    logic                rd_req, rd_miss, wr_go, enter_fill, fill_beat, last_beat;
    logic                wb_full, wb_match, wb_not_empty;
    logic [WSEL_W-1:0]   wr_word;
    logic [DATA_W-1:0]   wr_data;

    // Request qualification and handshake decode.
    assign hit_any    = |way_hit;
    assign victim     = lru_q[req_idx];
    assign rd_req     = cpu_rd & ~cpu_wr;
    assign rd_miss    = rd_req & ~hit_any;
    assign wr_go      = cpu_wr & ~wb_full;
    assign enter_fill = ((state_q == FILL_IDLE) && rd_miss && !wb_match) ||
                        ((state_q == FILL_WAIT) && !wb_match);
    assign fill_beat  = (state_q == FILL_BUSY) && mem_rd_valid;
    assign last_beat  = fill_beat && (beat_q == WSEL_W'(WORDS - 1));
    assign wr_word    = (state_q == FILL_BUSY) ? beat_q : req_word;
    assign wr_data    = (state_q == FILL_BUSY) ? mem_rd_data : cpu_wdata;

    // Processor-side outputs.
    assign cpu_hit   = hit_any;
    assign cpu_rdata = way_hit[1] ? way_rdata[1] : way_rdata[0];
    assign cpu_stall = (cpu_wr & wb_full) | rd_miss;

    // Memory-side refill request.
    assign mem_rd_req  = (state_q == FILL_BUSY);
    assign mem_rd_addr = {cpu_addr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};

    // Per-way instances and their write / invalidate / fill controls.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign way_inv[w]  = enter_fill && (victim == w[0]);
        assign way_wr[w]   = (wr_go && way_hit[w]) || (fill_beat && (fill_way_q == w[0]));
        assign way_fill[w] = last_beat && (fill_way_q == w[0]);

        wtc_way #(
            .TAG_W  (TAG_W),
            .INDEX_W(INDEX_W),
            .WSEL_W (WSEL_W)
        ) way_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (req_idx),
            .tag      (req_tag),
            .rd_word  (req_word),
            .hit      (way_hit[w]),
            .rdata    (way_rdata[w]),
            .wr_en    (way_wr[w]),
            .wr_word  (wr_word),
            .wr_data  (wr_data),
            .inv_en   (way_inv[w]),
            .fill_done(way_fill[w])
        );
    end

    // Store buffer toward memory.
    wtc_write_fifo #(
        .DEPTH  (WB_DEPTH),
        .BLK_LSB(OFFSET_W)
    ) wbuf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_go),
        .push_addr(cpu_addr),
        .push_data(cpu_wdata),
        .pop      (wb_not_empty & mem_wr_ack),
        .head_addr(mem_wr_addr),
        .head_data(mem_wr_data),
        .not_empty(wb_not_empty),
        .full     (wb_full),
        .q_blk    (cpu_addr[ADDR_W-1:OFFSET_W]),
        .match    (wb_match)
    );
    assign mem_wr_req = wb_not_empty;

    // Refill sequencer: wait for conflicting stores, then count refill beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FILL_IDLE;
            beat_q     <= '0;
            fill_way_q <= 1'b0;
        end else begin
            if (enter_fill) begin
                state_q    <= FILL_BUSY;
                beat_q     <= '0;
                fill_way_q <= victim;
            end else if ((state_q == FILL_IDLE) && rd_miss) begin
                state_q <= FILL_WAIT;
            end else if (fill_beat) begin
                beat_q <= beat_q + 1'b1;
                if (last_beat) begin
                    state_q <= FILL_IDLE;
                end
            end
        end
    end

    // Recency bit per set: holds the way to evict next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (last_beat) begin
            lru_q[req_idx] <= ~fill_way_q;
        end else if ((state_q == FILL_IDLE) && hit_any && (rd_req || wr_go)) begin
            lru_q[req_idx] <= ~way_hit[1];
        end
    end
endmodule

// File: rtl/wtc_cache_chk.sv
// Protocol checker for wtc_cache, attached by bind.
// Observes the ports plus the store buffer's full and block-match flags.
module wtc_cache_chk
    import wtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_hit,
    input logic              cpu_stall,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wr_req,
    input logic              mem_wr_ack,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              wb_full,
    input logic              wb_match
);
    // R1: a read that hits is never stalled.
    assert_rdhit_nostall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_hit) |-> !cpu_stall);

    // R2: refill address is block aligned.
    assert_refill_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[4:0] == 5'd0));

    // R2: refill address is held while the request stays up.
    assert_refill_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> (!mem_rd_req || $stable(mem_rd_addr)));

    // R2: the block being refilled never reports a hit mid-refill.
    assert_no_hit_in_refill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !cpu_hit);

    // R7: an unacknowledged store stays presented unchanged.
    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R8: a store into a full buffer stalls.
    assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && wb_full) |-> cpu_stall);

    // R9: no refill while a queued store targets the same block.
    assert_no_stale_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !wb_match);
endmodule

bind wtc_cache wtc_cache_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_hit    (cpu_hit),
    .cpu_stall  (cpu_stall),
    .mem_rd_req (mem_rd_req),
    .mem_rd_addr(mem_rd_addr),
    .mem_wr_req (mem_wr_req),
    .mem_wr_ack (mem_wr_ack),
    .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .wb_full    (wb_full),
    .wb_match   (wb_match)
);

// File: tb/wtc_cache_tb_top.sv
`timescale 1ns/1ps
module wtc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic        mem_wr_ack;
    logic        wr_ack_en = 1'b1;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    assign mem_wr_ack = wr_ack_en;

    wtc_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack)
    );

    // Memory model: written words override a fixed pattern.
    logic [31:0] mem_q [logic [31:0]];
    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (mem_q.exists(a)) return mem_q[a];
        return a ^ 32'hC0DE_0000;
    endfunction

    logic [31:0] wlog [0:63];
    int          wlog_n = 0;
    int          rf_cnt = 0;
    logic [31:0] rf_base = '0;
    bit          rf_busy = 1'b0;
    int          rf_wait = 0, rf_beat = 0;

    // Store drain: record at the edge where the design pops.
    always @(posedge clk) begin
        if (rst_n && mem_wr_req && mem_wr_ack) begin
            mem_q[mem_wr_addr] = mem_wr_data;
            if (wlog_n < 64) wlog[wlog_n] = mem_wr_addr;
            wlog_n++;
        end
    end

    // Refill responder: two idle cycles, then eight words in order.
    always @(negedge clk) begin
        if (!rst_n || !mem_rd_req) begin
            rf_busy = 1'b0;
            mem_rd_valid = 1'b0;
        end else if (!rf_busy) begin
            rf_busy = 1'b1; rf_wait = 2; rf_beat = 0;
            rf_base = mem_rd_addr; rf_cnt++;
            mem_rd_valid = 1'b0;
        end else if (rf_wait > 0) begin
            rf_wait--;
            mem_rd_valid = 1'b0;
        end else begin
            mem_rd_valid = 1'b1;
            mem_rd_data = mem_read(rf_base + 32'(4 * rf_beat));
            rf_beat++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_op(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic fhit, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        #1;
        fhit = cpu_hit;
        cyc = 0;
        while (cpu_stall && cyc < 1000) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic wait_drain();
        int n = 0;
        while (mem_wr_req && n < 1000) begin
            @(negedge clk); n++;
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        exp_hit;
        logic [31:0] exp_data;
        logic [7:0]  req;
    } vec_t;

    // Set 0 holds blocks at 0x1000, 0x2000, 0x3000 (tags 8, 16, 24).
    localparam vec_t VECS [0:12] = '{
        '{1'b0, 32'h0000_100C, 32'h0,         1'b0, 32'hC0DE_100C, 8'd2}, // R2 cold miss
        '{1'b0, 32'h0000_101C, 32'h0,         1'b1, 32'hC0DE_101C, 8'd1}, // R1 hit, word 7
        '{1'b0, 32'h0000_2004, 32'h0,         1'b0, 32'hC0DE_2004, 8'd3}, // R3 second way
        '{1'b0, 32'h0000_1000, 32'h0,         1'b1, 32'hC0DE_1000, 8'd3}, // R3 first still hits
        '{1'b0, 32'h0000_3008, 32'h0,         1'b0, 32'hC0DE_3008, 8'd4}, // R4 evicts 0x2000
        '{1'b0, 32'h0000_1004, 32'h0,         1'b1, 32'hC0DE_1004, 8'd4}, // R4 0x1000 kept
        '{1'b0, 32'h0000_2004, 32'h0,         1'b0, 32'hC0DE_2004, 8'd4}, // R4 evicts 0x3000
        '{1'b0, 32'h0000_3008, 32'h0,         1'b0, 32'hC0DE_3008, 8'd4}, // R4 evicts 0x1000
        '{1'b1, 32'h0000_2010, 32'h1111_2222, 1'b1, 32'h0,         8'd5}, // R5 store hit
        '{1'b0, 32'h0000_2010, 32'h0,         1'b1, 32'h1111_2222, 8'd5}, // R5 reads new word
        '{1'b1, 32'h0000_4020, 32'h3333_4444, 1'b0, 32'h0,         8'd6}, // R6 store miss
        '{1'b0, 32'h0000_4020, 32'h0,         1'b0, 32'h3333_4444, 8'd6}, // R6 no allocate
        '{1'b0, 32'h0000_4024, 32'h0,         1'b1, 32'hC0DE_4024, 8'd6}  // R6 block now filled
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic        fh;
        logic [31:0] rd;
        int          cyc, wc, rc, base_n;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet outputs after reset
        chk("R10 stall", {31'b0, cpu_stall}, 32'd0);
        chk("R10 mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
        chk("R10 mem_wr_req", {31'b0, mem_wr_req}, 32'd0);

        foreach (VECS[i]) begin
            cpu_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, fh, rd, cyc);
            chk($sformatf("R%0d vec%0d hit", VECS[i].req, i), {31'b0, fh}, {31'b0, VECS[i].exp_hit});
            if (!VECS[i].wr)
                chk($sformatf("R%0d vec%0d data", VECS[i].req, i), rd, VECS[i].exp_data);
            if (VECS[i].exp_hit || VECS[i].wr)
                chk($sformatf("R%0d vec%0d cycles", VECS[i].req, i), cyc, 0);
        end
        wait_drain();
        chk("R5 write-through reached memory", mem_read(32'h2010), 32'h1111_2222);

        // R7 / R2: a read miss issues no memory write and an aligned refill
        wc = wlog_n; rc = rf_cnt;
        cpu_op(1'b0, 32'h0000_5014, 32'h0, fh, rd, cyc);
        chk("R7 no write on read miss", wlog_n, wc);
        chk("R2 one refill", rf_cnt, rc + 1);
        chk("R2 refill base", rf_base, 32'h0000_5000);
        chk("R2 refill data", rd, 32'hC0DE_5014);

        // R8: four stores fill the buffer, the fifth stalls
        wr_ack_en = 1'b0;
        base_n = wlog_n;
        for (int i = 0; i < 4; i++) begin
            cpu_op(1'b1, 32'h0000_6000 + 32'(4 * i), 32'hF000_0000 + 32'(i), fh, rd, cyc);
            chk("R8 store accepted without stall", cyc, 0);
        end
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 32'h0000_6010; cpu_wdata = 32'hF000_0004;
        #1;
        for (int k = 0; k < 4; k++) begin
            chk("R8 stall while full", {31'b0, cpu_stall}, 32'd1);
            @(negedge clk); #1;
        end
        wr_ack_en = 1'b1;
        cyc = 0;
        while (cpu_stall && cyc < 100) begin
            @(negedge clk); #1; cyc++;
        end
        chk("R8 released after one drain", cyc, 1);
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        wait_drain();
        for (int i = 0; i < 5; i++)
            chk("R7 drain order", wlog[base_n + i], 32'h0000_6000 + 32'(4 * i));
        chk("R7 last store data", mem_read(32'h6010), 32'hF000_0004);

        // R9: refill waits for a queued store to the same block
        wr_ack_en = 1'b0;
        cpu_op(1'b1, 32'h0000_7008, 32'hABCD_0001, fh, rd, cyc);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 32'h0000_7000;
        #1;
        for (int k = 0; k < 5; k++) begin
            chk("R9 no refill while store queued", {31'b0, mem_rd_req}, 32'd0);
            @(negedge clk); #1;
        end
        wr_ack_en = 1'b1;
        cyc = 0;
        while (cpu_stall && cyc < 100) begin
            @(negedge clk); #1; cyc++;
        end
        chk("R9 refilled word", cpu_rdata, 32'hC0DE_7000);
        @(posedge clk); #1;
        cpu_rd = 1'b0;
        cpu_op(1'b0, 32'h0000_7008, 32'h0, fh, rd, cyc);
        chk("R9 fresh data after drain", rd, 32'hABCD_0001);
        chk("R9 hit", {31'b0, fh}, 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule